// File: doc/BRIEF.md
# Early-Transmit Threshold Start Controller

This block sits between a 32-bit transmit FIFO write port and a byte-wide transmit engine, and decides when a frame starts to go out. Software sets a 6-bit threshold and can write a start command. While a frame is being filled, the block counts the bytes stored for it. When that count reaches 4·(8·T+1) bytes, where T is the threshold in force for the frame, the frame starts as if software had issued the start command. Once started, the block sends exactly the frame-length number of bytes to the transmit engine, one byte per accepted cycle, and then raises a done pulse.

The threshold value 63 turns automatic starting off. At that value only the start command launches a frame. Software also uses the start command for any frame shorter than the threshold level. The block does no underrun checking. If writes fall behind the drain, the read side runs past the write side and sends whatever the FIFO locations hold. Both pointers are brought out so that this case can be seen.

Top module: `early_tx_ctrl`

## Requirements
- R1: After reset the threshold is 63, `tx_valid_o`, `tx_done_o` and `start_pend_o` are low, and both pointers are 0.
- R2: With a threshold of 63 in force, no frame starts without a start command, however many bytes are stored.
- R3: With a threshold T other than 63, `tx_valid_o` rises in the second cycle after the write that brings the frame's stored byte count to at least 4·(8·T+1) bytes. Each write adds 4 bytes, so T=0 starts after 1 word and T=1 after 9 words.
- R4: A start command (`start_we_i`) written while no frame is being sent starts the pending frame even when it is shorter than the threshold level. `start_pend_o` reads 1 from the cycle after that write.
- R5: A started frame delivers exactly `frame_len_i` bytes (1 to 2047, latched at the frame's first word). Bytes go out least significant first within each word. A byte moves on each cycle that `tx_valid_o` and `tx_ready_i` are both high, and `tx_data_o` holds steady while `tx_ready_i` is low.
- R6: `tx_done_o` is a one-cycle pulse in the cycle after the last byte is accepted, with `tx_valid_o` low.
- R7: The start command clears itself when the frame finishes. A start command written while a frame is being sent has no effect, and it does not carry over to the next frame.
- R8: The threshold is captured when a frame's first word is written. A threshold write made after that point applies only to later frames.
- R9: There is no underrun protection. The read pointer keeps advancing past the write pointer, and the stored contents of those locations are sent.
- R10: At the end of a frame whose length is not a multiple of 4, the read pointer moves on to the next word, so the next frame starts on a word boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| thr_we_i | input | 1 | Threshold register write strobe |
| thr_i | input | 6 | Threshold value to write (63 = automatic start off) |
| start_we_i | input | 1 | Start command write strobe |
| fifo_we_i | input | 1 | FIFO word write strobe |
| fifo_wdata_i | input | 32 | FIFO word; byte 0 in bits 7:0 goes out first |
| frame_len_i | input | 11 | Frame length in bytes, taken with the frame's first word |
| tx_ready_i | input | 1 | Transmit engine accepts a byte this cycle |
| tx_data_o | output | 8 | Current frame byte |
| tx_valid_o | output | 1 | A frame is being sent and `tx_data_o` is valid |
| tx_done_o | output | 1 | One-cycle pulse after the last byte |
| start_pend_o | output | 1 | Start command is set for the current frame |
| wr_ptr_o | output | 9 | FIFO write pointer (words) |
| rd_ptr_o | output | 9 | FIFO read pointer (words) |

## Verification
An error in the captured threshold or in the byte counter shows up as `tx_valid_o` rising one or more cycles too early or too late relative to the triggering write. The bench therefore checks the exact cycle of the rise. If the length countdown or the byte lane index is wrong, the bytes come out shifted, reordered or miscounted, and the done pulse moves. This is visible as soon as the frame ends. If the read pointer does not move on after a partial last word, the two pointers stay apart and the next frame is corrupted from its first byte.

// File: rtl/early_tx_pkg.sv
package early_tx_pkg;
  localparam int unsigned THR_W   = 6;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned LANES   = WORD_W / BYTE_W;
  localparam logic [THR_W-1:0] THR_OFF = '1;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_FILL = 2'd1,
    FR_SEND = 2'd2
  } frame_st_e;
endpackage

// File: rtl/etx_fifo.sv
module etx_fifo #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  input  logic             rd_adv_i,
  output logic [31:0]      rd_word_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o
);
  logic [31:0]      mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  always_ff @(posedge clk_i) begin
    if (we_i) mem[wr_ptr] <= wdata_i;
  end

  // no full/empty guard: pointers free-run by design
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (we_i)     wr_ptr <= wr_ptr + 1'b1;
      if (rd_adv_i) rd_ptr <= rd_ptr + 1'b1;
    end
  end

  assign rd_word_o = mem[rd_ptr];
  assign wr_ptr_o  = wr_ptr;
  assign rd_ptr_o  = rd_ptr;
endmodule

// File: rtl/etx_trigger.sv
module etx_trigger
  import early_tx_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             thr_we_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic             start_we_i,
  input  logic             fifo_we_i,
  input  logic             finish_i,
  output logic             open_o,
  output logic             go_o,
  output logic             send_o,
  output logic             pend_o
);
  frame_st_e        st_q;
  logic [THR_W-1:0] thr_reg, thr_act;
  logic [CNT_W-1:0] byte_cnt, level;
  logic             newtx;
  logic             auto_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) thr_reg <= THR_OFF;
    else if (thr_we_i) thr_reg <= thr_i;
  end

  assign level    = CNT_W'((32'(thr_act) * 8 + 1) * 4);
  assign auto_hit = (thr_act != THR_OFF) && (byte_cnt >= level);
  assign open_o   = (st_q == FR_IDLE) && fifo_we_i;
  assign go_o     = (st_q == FR_FILL) && (auto_hit || newtx);
  assign send_o   = (st_q == FR_SEND);
  assign pend_o   = newtx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= FR_IDLE;
      thr_act  <= THR_OFF;
      byte_cnt <= '0;
      newtx    <= 1'b0;
    end else begin
      unique case (st_q)
        FR_IDLE: begin
          if (start_we_i) newtx <= 1'b1;
          if (fifo_we_i) begin
            st_q     <= FR_FILL;
            thr_act  <= thr_reg;
            byte_cnt <= CNT_W'(4);
          end
        end
        FR_FILL: begin
          if (start_we_i) newtx <= 1'b1;
          if (fifo_we_i && byte_cnt <= {CNT_W{1'b1}} - CNT_W'(4))
            byte_cnt <= byte_cnt + CNT_W'(4);
          if (go_o) st_q <= FR_SEND;
        end
        FR_SEND: begin
          // second trigger in the same frame is dropped
          if (finish_i) begin
            st_q     <= FR_IDLE;
            newtx    <= 1'b0;
            byte_cnt <= '0;
          end
        end
        default: st_q <= FR_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/etx_drain.sv
module etx_drain
  import early_tx_pkg::*;
#(
  parameter int unsigned LEN_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               open_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               go_i,
  input  logic               send_i,
  input  logic               ready_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [BYTE_W-1:0]  data_o,
  output logic               valid_o,
  output logic               rd_adv_o,
  output logic               finish_o,
  output logic               done_o
);
  localparam int unsigned IDX_W = $clog2(LANES);

  logic [LEN_W-1:0]  len_q, remain;
  logic [IDX_W-1:0]  idx;
  logic [BYTE_W-1:0] lane [LANES];
  logic              hs, last_lane;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane[g] = word_i[g*BYTE_W +: BYTE_W];
  end

  assign hs        = send_i && ready_i;
  assign last_lane = (idx == IDX_W'(LANES - 1));
  assign finish_o  = hs && (remain == LEN_W'(1));
  assign rd_adv_o  = hs && (last_lane || remain == LEN_W'(1));
  assign valid_o   = send_i;
  assign data_o    = lane[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q  <= '0;
      remain <= '0;
      idx    <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= finish_o;
      if (open_i) len_q <= len_i;
      if (go_i) begin
        remain <= len_q;
        idx    <= '0;
      end else if (hs) begin
        remain <= remain - 1'b1;
        idx    <= finish_o ? '0 : idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/early_tx_ctrl.sv
module early_tx_ctrl
  import early_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned LEN_W = 11,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = PTR_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              thr_we_i,
  input  logic [THR_W-1:0]  thr_i,
  input  logic              start_we_i,
  input  logic              fifo_we_i,
  input  logic [WORD_W-1:0] fifo_wdata_i,
  input  logic [LEN_W-1:0]  frame_len_i,
  input  logic              tx_ready_i,
  output logic [BYTE_W-1:0] tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_done_o,
  output logic              start_pend_o,
  output logic [PTR_W-1:0]  wr_ptr_o,
  output logic [PTR_W-1:0]  rd_ptr_o
);
  logic              open_w, go_w, send_w, finish_w, rd_adv_w;
  logic [WORD_W-1:0] rd_word_w;

  etx_fifo #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (fifo_we_i),
    .wdata_i  (fifo_wdata_i),
    .rd_adv_i (rd_adv_w),
    .rd_word_o(rd_word_w),
    .wr_ptr_o (wr_ptr_o),
    .rd_ptr_o (rd_ptr_o)
  );

  etx_trigger #(.CNT_W(CNT_W)) u_trig (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .thr_we_i  (thr_we_i),
    .thr_i     (thr_i),
    .start_we_i(start_we_i),
    .fifo_we_i (fifo_we_i),
    .finish_i  (finish_w),
    .open_o    (open_w),
    .go_o      (go_w),
    .send_o    (send_w),
    .pend_o    (start_pend_o)
  );

  etx_drain #(.LEN_W(LEN_W)) u_drain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .open_i  (open_w),
    .len_i   (frame_len_i),
    .go_i    (go_w),
    .send_i  (send_w),
    .ready_i (tx_ready_i),
    .word_i  (rd_word_w),
    .data_o  (tx_data_o),
    .valid_o (tx_valid_o),
    .rd_adv_o(rd_adv_w),
    .finish_o(finish_w),
    .done_o  (tx_done_o)
  );
endmodule

// File: rtl/etx_checker.sv
module etx_checker #(
  parameter int unsigned CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_valid_i,
  input logic             tx_ready_i,
  input logic [7:0]       tx_data_i,
  input logic             tx_done_i,
  input logic             pend_i,
  input logic [5:0]       thr_act_i,
  input logic [CNT_W-1:0] byte_cnt_i
);
  a_r2_no_auto_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_i) && (thr_act_i == 6'h3f) |-> pend_i);

  a_r3_start_at_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_valid_i) && (thr_act_i != 6'h3f) && !pend_i
      |-> (32'(byte_cnt_i) >= (32'(thr_act_i) * 8 + 1) * 4));

  a_r5_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && !tx_ready_i |=> tx_valid_i && $stable(tx_data_i));

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |=> !tx_done_i);

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |-> !tx_valid_i);

  a_r7_pend_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_i |-> !pend_i);
endmodule

bind early_tx_ctrl etx_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_i(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_data_i (tx_data_o),
  .tx_done_i (tx_done_o),
  .pend_i    (start_pend_o),
  .thr_act_i (u_trig.thr_act),
  .byte_cnt_i(u_trig.byte_cnt)
);

// File: tb/tb_early_tx_ctrl.sv
`timescale 1ns/1ps
module tb_early_tx_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        thr_we_i = 1'b0;
  logic [5:0]  thr_i = '0;
  logic        start_we_i = 1'b0;
  logic        fifo_we_i = 1'b0;
  logic [31:0] fifo_wdata_i = '0;
  logic [10:0] frame_len_i = '0;
  logic        tx_ready_i = 1'b0;
  logic [7:0]  tx_data_o;
  logic        tx_valid_o, tx_done_o, start_pend_o;
  logic [8:0]  wr_ptr_o, rd_ptr_o;

  int errors = 0, checks = 0;
  int cyc = 0;
  bit rdy = 1'b0, stall = 1'b0, finished = 1'b0;
  logic [7:0] rx [4096];
  int rx_n = 0, last_hs = 0, done_cnt = 0, done_gap = 0, done_len = 0;

  always #10 clk = ~clk;

  early_tx_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .thr_we_i(thr_we_i), .thr_i(thr_i),
    .start_we_i(start_we_i), .fifo_we_i(fifo_we_i), .fifo_wdata_i(fifo_wdata_i),
    .frame_len_i(frame_len_i), .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o),
    .tx_valid_o(tx_valid_o), .tx_done_o(tx_done_o), .start_pend_o(start_pend_o),
    .wr_ptr_o(wr_ptr_o), .rd_ptr_o(rd_ptr_o)
  );

  always @(posedge clk) begin
    cyc++;
    #2;
    tx_ready_i = stall ? ((cyc % 3) != 0) : rdy;
  end

  always @(negedge clk) begin
    if (tx_valid_o && tx_ready_i) begin
      if (rx_n < 4096) rx[rx_n] = tx_data_o;
      rx_n++;
      last_hs = cyc;
    end
    if (tx_done_o) begin
      done_cnt++;
      done_gap = cyc - last_hs;
      done_len = rx_n;
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: act=timeout exp=finish");
    summary();
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_thr(logic [5:0] v);
    @(posedge clk); #2; thr_we_i = 1'b1; thr_i = v;
    @(posedge clk); #2; thr_we_i = 1'b0;
  endtask

  task automatic start_cmd();
    @(posedge clk); #2; start_we_i = 1'b1;
    @(posedge clk); #2; start_we_i = 1'b0;
  endtask

  // word j of a frame holds bytes seed+4j .. seed+4j+3, low byte first
  task automatic wr_words(logic [7:0] seed, int first, int n, int len);
    for (int j = first; j < first + n; j++) begin
      @(posedge clk); #2;
      fifo_we_i = 1'b1;
      frame_len_i = 11'(len);
      for (int b = 0; b < 4; b++)
        fifo_wdata_i[b*8 +: 8] = seed + 8'(4*j + b);
    end
    @(posedge clk); #2; fifo_we_i = 1'b0;
  endtask

  task automatic wait_done(int prev);
    for (int i = 0; i < 6000 && done_cnt == prev; i++) @(posedge clk);
    #2;
  endtask

  task automatic check_frame(string req, logic [7:0] seed, int len, int prev);
    int bad = 0;
    wait_done(prev);
    chk(done_cnt == prev + 1, {req, " done pulse count"}, done_cnt - prev, 1);
    chk(done_len == len, {req, " byte count"}, done_len, len);
    chk(done_gap == 1, {req, " done one cycle after last byte"}, done_gap, 1);
    for (int i = 0; i < len && i < 4096; i++)
      if (rx[i] != seed + 8'(i)) bad++;
    chk(bad == 0, {req, " byte order/data mismatches"}, bad, 0);
    chk(rd_ptr_o == wr_ptr_o, {req, " pointers aligned"}, int'(rd_ptr_o), int'(wr_ptr_o));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!tx_valid_o, "R1 valid low", int'(tx_valid_o), 0);
    chk(!tx_done_o, "R1 done low", int'(tx_done_o), 0);
    chk(!start_pend_o, "R1 pend low", int'(start_pend_o), 0);
    chk(wr_ptr_o == 0 && rd_ptr_o == 0, "R1 pointers zero", int'(wr_ptr_o) + int'(rd_ptr_o), 0);
  endtask

  task automatic t_disabled();
    int p = done_cnt;
    rx_n = 0; rdy = 1'b1;
    wr_words(8'h10, 0, 20, 80);
    idle(10);
    @(negedge clk);
    chk(!tx_valid_o, "R1 R2 no start at threshold 63", int'(tx_valid_o), 0);
    start_cmd();
    @(negedge clk);
    chk(start_pend_o || tx_valid_o, "R4 start command taken", int'(start_pend_o), 1);
    check_frame("R5", 8'h10, 80, p);
    @(negedge clk);
    chk(!start_pend_o, "R7 start self-clears", int'(start_pend_o), 0);
  endtask

  task automatic t_thr1();
    int p = done_cnt;
    rx_n = 0; rdy = 1'b0;
    set_thr(6'd1);
    wr_words(8'h40, 0, 8, 40);
    idle(5);
    @(negedge clk);
    chk(!tx_valid_o, "R3 no start at 32 bytes (T=1)", int'(tx_valid_o), 0);
    wr_words(8'h40, 8, 1, 40);
    @(negedge clk);
    chk(!tx_valid_o, "R3 not yet one cycle after 36th byte", int'(tx_valid_o), 0);
    @(negedge clk);
    chk(tx_valid_o, "R3 start two cycles after 36th byte", int'(tx_valid_o), 1);
    wr_words(8'h40, 9, 1, 40);
    stall = 1'b1;
    check_frame("R5 stalled", 8'h40, 40, p);
    stall = 1'b0;
  endtask

  task automatic t_thr0();
    int p = done_cnt;
    rx_n = 0; rdy = 1'b0;
    set_thr(6'd0);
    wr_words(8'h80, 0, 1, 8);
    @(negedge clk);
    chk(!tx_valid_o, "R3 T=0 not yet", int'(tx_valid_o), 0);
    @(negedge clk);
    chk(tx_valid_o, "R3 T=0 start after one word", int'(tx_valid_o), 1);
    wr_words(8'h80, 1, 1, 8);
    rdy = 1'b1;
    check_frame("R3 T=0", 8'h80, 8, p);
  endtask

  task automatic t_short();
    int p = done_cnt;
    rx_n = 0; rdy = 1'b1;
    set_thr(6'd2);
    wr_words(8'hA0, 0, 3, 10);
    idle(8);
    @(negedge clk);
    chk(!tx_valid_o, "R4 short frame waits", int'(tx_valid_o), 0);
    start_cmd();
    check_frame("R4 R10 partial word", 8'hA0, 10, p);
  endtask

  task automatic t_latch();
    int p = done_cnt;
    rx_n = 0; rdy = 1'b0;
    set_thr(6'd0);
    wr_words(8'hC0, 0, 1, 12);
    set_thr(6'h3f);
    @(negedge clk);
    chk(tx_valid_o, "R8 captured threshold still starts frame", int'(tx_valid_o), 1);
    wr_words(8'hC0, 1, 2, 12);
    rdy = 1'b1;
    check_frame("R8 first frame", 8'hC0, 12, p);
    p = done_cnt; rx_n = 0; rdy = 1'b0;
    wr_words(8'h20, 0, 3, 12);
    idle(6);
    @(negedge clk);
    chk(!tx_valid_o, "R8 new threshold 63 applies to next frame", int'(tx_valid_o), 0);
    start_cmd();
    idle(2);
    start_cmd();
    rdy = 1'b1;
    check_frame("R7 second frame", 8'h20, 12, p);
    @(negedge clk);
    chk(!start_pend_o, "R7 start during send ignored", int'(start_pend_o), 0);
    p = done_cnt; rx_n = 0;
    wr_words(8'h60, 0, 1, 4);
    idle(6);
    @(negedge clk);
    chk(!tx_valid_o, "R7 ignored start does not carry over", int'(tx_valid_o), 0);
    start_cmd();
    check_frame("R7 third frame", 8'h60, 4, p);
  endtask

  task automatic t_underrun();
    int p = done_cnt;
    int w0 = int'(wr_ptr_o);
    int bad = 0;
    rx_n = 0; rdy = 1'b1;
    set_thr(6'd0);
    wr_words(8'hE0, 0, 1, 16);
    wait_done(p);
    chk(done_len == 16, "R9 full length sent on underrun", done_len, 16);
    for (int i = 0; i < 4; i++) if (rx[i] != 8'hE0 + 8'(i)) bad++;
    chk(bad == 0, "R9 stored head bytes", bad, 0);
    chk(int'(wr_ptr_o) == (w0 + 1) % 512, "R9 write pointer", int'(wr_ptr_o), (w0 + 1) % 512);
    chk(int'(rd_ptr_o) == (w0 + 4) % 512, "R9 read pointer passes write", int'(rd_ptr_o), (w0 + 4) % 512);
  endtask

  initial begin
    idle(3);
    t_reset();
    @(posedge clk); #2; rst_ni = 1'b1;
    t_reset();
    t_disabled();
    t_thr1();
    t_thr0();
    t_short();
    t_latch();
    t_underrun();
    idle(4);
    summary();
  end
endmodule